// File: doc/BRIEF.md
# Facility Data Link Receive Collector

This block gathers the data link bits that a T1 framer recovers, one per extended-superframe data link slot, and packs them into bytes for a host controller. Each bit comes with a one-cycle strobe. Bits enter LSB-first, so the first bit received lands in bit 0 of the finished byte. When eight bits have been collected, the byte goes into a holding register and a sticky buffer-full status is set. A new byte comes roughly every 2 ms, so the host has that long to fetch each byte before the next one replaces it.

An optional zero destuffer follows the LAPD-style stuffing rule used on the data link. Senders insert a 0 after any five consecutive 1s, so that data never looks like a flag (01111110) or an abort (all ones). When the destuffer is on, such a stuffed 0 is removed before it reaches the shift register. Each finished byte is compared with two host-programmed pattern bytes. A hit on either pattern sets a sticky match status, so the host can ignore the link until a byte of interest turns up. Each status bit has its own enable mask, and the masked statuses drive an active-low interrupt.

Register map (3-bit address, 8-bit data):
- 0 holds the received byte and is read-only.
- 1 holds the status: bit 0 is full, bit 1 is match, bit 2 is overrun. Writing 1 to a bit clears it.
- 2 holds the interrupt enables, using the same bit positions as the status.
- 3 holds pattern A.
- 4 holds pattern B.
- 5 holds the control bits; bit 0 turns the destuffer on.
- Any other address reads as zero.

Top module: `fdl_rx_collector`

## Requirements
- R1: After reset the following all read 0: the received byte, status, interrupt enables, both patterns and control. irq_n is 1.
- R2: Each accepted bit shifts in LSB-first. The byte register (address 0) takes the completed byte at the clock edge that accepts the eighth bit, so the first accepted bit ends up in bit 0.
- R3: Completing a byte sets status bit 0 (full) at the same edge.
- R4: If the completed byte equals pattern A (address 3) or pattern B (address 4), status bit 1 (match) is set at the same edge as full.
- R5: If a byte completes while full is already set, the byte register is overwritten and status bit 2 (overrun) is set.
- R6: Writing the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. A set that happens in the same cycle wins over the clear.
- R7: irq_n is 0 exactly when some status bit is 1 and its enable bit at address 2 (same bit position) is also 1.
- R8: When control bit 0 is 1, a received 0 that follows five consecutive 1s is discarded and does not count toward the byte.
- R9: The run-of-ones count restarts on every received 0 and is held at zero while control bit 0 is 0. With the destuffer off, every strobed bit is shifted in.
- R10: bit_data has no effect in cycles where bit_strobe is 0.
- R11: Registers at addresses 2 through 5 read back what was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | Marks a valid data link bit this cycle |
| bit_data | input | 1 | Data link bit value |
| host_wr | input | 1 | Register write enable |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for host_addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is a stuffed zero that sits right on a byte boundary, or in the middle of a long run of ones that spans two bytes. At that point the destuffer's count must carry across the byte edge while the shift counter wraps. The bench produces this by stuffing every byte value from 0 to 255 as one continuous stream and feeding the result in. Runs of ones then cross byte edges in every possible alignment, and each recovered byte must match the value sent. A second situation, a status clear landing in the same cycle as a new byte, is produced by issuing the status write together with the eighth strobe.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_MASK = 3'd2;
  localparam logic [AW-1:0] A_PATA = 3'd3;
  localparam logic [AW-1:0] A_PATB = 3'd4;
  localparam logic [AW-1:0] A_CTRL = 3'd5;

  localparam int ST_FULL  = 0;
  localparam int ST_MATCH = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_W     = 3;

  // Saturating increment of the run-of-ones counter.
  function automatic logic [3:0] ones_step(logic [3:0] cur, logic b, logic [3:0] cap);
    if (!b) return 4'd0;
    if (cur >= cap) return cap;
    return cur + 4'd1;
  endfunction

  // Byte assembly: new bit enters at the top so the first bit reaches bit 0.
  function automatic logic [7:0] shift_lsb_first(logic [7:0] cur, logic b);
    return {b, cur[7:1]};
  endfunction
endpackage

// File: rtl/fdl_destuff.sv
module fdl_destuff #(
  parameter int ONES_LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  input  logic bit_in,
  output logic accept,
  output logic drop
);
  import fdl_rx_pkg::*;
  localparam logic [3:0] LIM = 4'(ONES_LIM);
  localparam logic [3:0] CAP = 4'(ONES_LIM + 1);

  logic [3:0] ones_q;

  assign drop   = strobe && en && !bit_in && (ones_q == LIM);
  assign accept = strobe && !drop;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) ones_q <= '0;
    else if (strobe) ones_q <= ones_step(ones_q, bit_in, CAP);
  end

  assert_drop_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ones_q == 4'd0));
  assert_off_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ones_q == 4'd0));
endmodule

// File: rtl/fdl_shift.sv
module fdl_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         bit_in,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);
  import fdl_rx_pkg::*;
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sr_n;

  always_comb begin
    sr_n = {bit_in, sr_q[W-1:1]};
  end

  assign byte_done = accept && (cnt_q == CW'(W-1));
  assign byte_val  = sr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      sr_q  <= sr_n;
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cnt_q == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cnt_q) && $stable(sr_q));
endmodule

// File: rtl/fdl_match.sv
module fdl_match #(
  parameter int W    = 8,
  parameter int NPAT = 2
) (
  input  logic [NPAT-1:0][W-1:0] pats,
  input  logic [W-1:0]           byte_val,
  output logic                   hit
);
  logic [NPAT-1:0] eq;

  for (genvar g = 0; g < NPAT; g++) begin : g_cmp
    assign eq[g] = (pats[g] == byte_val);
  end

  assign hit = |eq;
endmodule

// File: rtl/fdl_regs.sv
module fdl_regs #(
  parameter int W    = 8,
  parameter int NPAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic [2:0]             host_addr,
  input  logic [W-1:0]           host_wdata,
  output logic [W-1:0]           host_rdata,
  input  logic                   byte_done,
  input  logic [W-1:0]           byte_val,
  input  logic                   hit,
  output logic [NPAT-1:0][W-1:0] pats,
  output logic                   destuff_en,
  output logic                   irq_n
);
  import fdl_rx_pkg::*;

  logic [W-1:0]    data_q, pata_q, patb_q, ctrl_q;
  logic [ST_W-1:0] st_q, mask_q, st_set, st_clr;
  logic            wr_stat;

  assign wr_stat = host_wr && (host_addr == A_STAT);

  always_comb begin
    st_set           = '0;
    st_set[ST_FULL]  = byte_done;
    st_set[ST_MATCH] = byte_done && hit;
    st_set[ST_OVR]   = byte_done && st_q[ST_FULL];
    st_clr           = wr_stat ? host_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      st_q   <= '0;
      mask_q <= '0;
      pata_q <= '0;
      patb_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (byte_done) data_q <= byte_val;
      st_q <= st_set | (st_q & ~st_clr);
      if (host_wr) begin
        case (host_addr)
          A_MASK:  mask_q <= host_wdata[ST_W-1:0];
          A_PATA:  pata_q <= host_wdata;
          A_PATB:  patb_q <= host_wdata;
          A_CTRL:  ctrl_q <= host_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_DATA:  host_rdata = data_q;
      A_STAT:  host_rdata = W'(st_q);
      A_MASK:  host_rdata = W'(mask_q);
      A_PATA:  host_rdata = pata_q;
      A_PATB:  host_rdata = patb_q;
      A_CTRL:  host_rdata = ctrl_q;
      default: host_rdata = '0;
    endcase
  end

  assign pats       = {patb_q, pata_q};
  assign destuff_en = ctrl_q[0];
  assign irq_n      = ~|(st_q & mask_q);

  assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (data_q == $past(byte_val)));
  assert_full_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> st_q[ST_FULL]);
  assert_match_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && hit) |=> st_q[ST_MATCH]);
  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st_q[ST_FULL]) |=> st_q[ST_OVR]);
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && host_wdata[ST_MATCH] && !(byte_done && hit)) |=> !st_q[ST_MATCH]);
  assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && mask_q[ST_FULL] && !(host_wr && host_addr == A_MASK)) |=> !irq_n);
endmodule

// File: rtl/fdl_rx_collector.sv
module fdl_rx_collector #(
  parameter int W        = 8,
  parameter int NPAT     = 2,
  parameter int ONES_LIM = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_strobe,
  input  logic         bit_data,
  input  logic         host_wr,
  input  logic [2:0]   host_addr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic         irq_n
);
  logic                   accept, drop, byte_done, hit, destuff_en;
  logic [W-1:0]           byte_val;
  logic [NPAT-1:0][W-1:0] pats;

  fdl_destuff #(.ONES_LIM(ONES_LIM)) u_destuff (
    .clk(clk), .rst_n(rst_n), .en(destuff_en), .strobe(bit_strobe),
    .bit_in(bit_data), .accept(accept), .drop(drop)
  );

  fdl_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .accept(accept), .bit_in(bit_data),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  fdl_match #(.W(W), .NPAT(NPAT)) u_match (
    .pats(pats), .byte_val(byte_val), .hit(hit)
  );

  fdl_regs #(.W(W), .NPAT(NPAT)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .byte_done(byte_done),
    .byte_val(byte_val), .hit(hit), .pats(pats), .destuff_en(destuff_en),
    .irq_n(irq_n)
  );

  assert_strobe_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> bit_strobe);
  assert_drop_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !byte_done);
endmodule

// File: tb/sim_fdl_rx_collector.sv
module sim_fdl_rx_collector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_strobe = 1'b0, bit_data = 1'b0, host_wr = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       irq_n;
  int         checks = 0, failures = 0;

  always #5 clk = ~clk;

  fdl_rx_collector u0 (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_data(bit_data),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // One idle cycle with inverted data (R10), then one strobed bit.
  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_strobe = 1'b0; bit_data = ~b;
    @(negedge clk);
    bit_strobe = 1'b1; bit_data = b;
    @(negedge clk);
    bit_strobe = 1'b0; bit_data = b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  logic [7:0] r;
  int ones;

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      chk("R1 reset reg", r, 0);
    end
    chk("R1 reset irq_n", irq_n, 1);

    // R11 readback
    wr(3'd3, 8'h3C); wr(3'd4, 8'hA5); wr(3'd2, 8'h00);
    rd(3'd3, r); chk("R11 patA", r, 8'h3C);
    rd(3'd4, r); chk("R11 patB", r, 8'hA5);
    rd(3'd2, r); chk("R11 mask", r, 8'h00);

    // Sweep all bytes, destuffer off: R2 R3 R4 R9 R10
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v));
      rd(3'd0, r); chk("R2 byte", r, v);
      rd(3'd1, r);
      chk("R3/R4 status", r, {6'd0, (v == 8'h3C || v == 8'hA5), 1'b1});
      wr(3'd1, 8'h07);
    end
    rd(3'd1, r); chk("R6 cleared", r, 0);

    // R5 overrun, R7 interrupt
    send_byte(8'h11);
    chk("R7 masked off irq_n", irq_n, 1);
    send_byte(8'h22);
    rd(3'd0, r); chk("R5 overwrite", r, 8'h22);
    rd(3'd1, r); chk("R5 overrun", r, 8'h05);
    wr(3'd2, 8'h04);
    chk("R7 overrun enabled", irq_n, 0);
    wr(3'd1, 8'h02);
    rd(3'd1, r); chk("R6 write0 keeps", r, 8'h05);
    wr(3'd1, 8'h04);
    chk("R7 release", irq_n, 1);
    wr(3'd2, 8'h01);
    chk("R7 full enabled", irq_n, 0);
    wr(3'd1, 8'h01);
    chk("R7 cleared", irq_n, 1);

    // R6 set wins over same-cycle clear
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    @(negedge clk);
    bit_strobe = 1'b1; bit_data = 1'b1;
    host_wr = 1'b1; host_addr = 3'd1; host_wdata = 8'h01;
    @(negedge clk);
    bit_strobe = 1'b0; host_wr = 1'b0;
    rd(3'd1, r); chk("R6 set wins", r, 8'h01);
    rd(3'd0, r); chk("R2 byte 0x80", r, 8'h80);
    wr(3'd1, 8'h07); wr(3'd2, 8'h00);

    // R8: stuffed stream of all byte values, destuffer on
    wr(3'd5, 8'h01);
    ones = 0;
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 8; i++) begin
        send_bit(v[i]);
        if (v[i]) ones++; else ones = 0;
        if (ones == 5) begin send_bit(1'b0); ones = 0; end
      end
      rd(3'd0, r); chk("R8 destuffed byte", r, v);
      rd(3'd1, r); chk("R8 full", r[0], 1);
      wr(3'd1, 8'h07);
    end

    // R9: disabling resets the ones run
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    wr(3'd5, 8'h00); wr(3'd5, 8'h01);
    send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    rd(3'd1, r); chk("R9 full after reset run", r[0], 1);
    rd(3'd0, r); chk("R9 byte", r, 8'h1F);
    wr(3'd1, 8'h07);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule